// File: doc/BRIEF.md
# Sample Fetch Bus Stall Controller

This block lets an audio sample reader borrow exactly one memory cycle from a CPU bus. When a fetch request arrives, it pulls the bus ready line low and keeps it low for a stall of 1 to 5 cycles. The stall length depends on the bus activity at the moment of the request. It can be a CPU read, a single write, one of the two writes of a double write, or a phase of a sprite-memory DMA transfer.

The CPU keeps writing through a low ready line, so the controller inserts idle cycles until any write that may be in progress has finished. A DMA transfer in progress gets a shorter pause. Only the last stalled cycle puts the sample address on the bus, and the returned byte is captured at the end of that cycle. Ready then rises, and a one-cycle done strobe presents the byte.

A request that arrives on an odd bus cycle costs one extra alignment cycle, so that the fetch lands on the cycle the reader expects. Requests that arrive during a stall are dropped.

Top module: `fetch_stall_ctrl`

## Requirements
- R1: Reset state: after reset `rdy` is 1 and `busDrive` is 0, `fetchDone` is 0 and `busAddr` is 0.
- R2: A request accepted on a cycle with none of the write or DMA flags set counts as a CPU read and holds `rdy` low for 4 cycles (with `cycleEven` = 1).
- R3: A request accepted with `cpuWrite` or `cpuDblSecond` set, and no flag of higher priority, holds `rdy` low for 3 cycles.
- R4: A request accepted with `cpuDblFirst` set, and no DMA flag set, holds `rdy` low for 4 cycles.
- R5: A request accepted with `dmaActive` or `dmaTrigger` set, and neither `dmaLast` nor `dmaSecondLast` set, holds `rdy` low for 2 cycles. The DMA engine pauses through the same low `rdy`.
- R6: A request accepted with `dmaSecondLast` set, and `dmaLast` clear, holds `rdy` low for 1 cycle.
- R7: A request accepted with `dmaLast` set holds `rdy` low for 3 cycles.
- R8: A request accepted with `cycleEven` = 0 holds `rdy` low for one cycle more than the same case with `cycleEven` = 1.
- R9: `busDrive` is 1 only in the last cycle in which `rdy` is low. In that cycle `busAddr` equals the address latched at acceptance. In every other cycle `busAddr` is 0.
- R10: In the cycle after the last stalled cycle, `fetchDone` is 1 for exactly one cycle, `rdy` is 1, and `fetchData` holds the `busRdata` value sampled at the end of the last stalled cycle.
- R11: A request that arrives while `rdy` is low is ignored. The stall length, the driven address and the captured byte of the fetch in progress do not change.
- R12: The case flags are sampled only in the accept cycle. When several flags are set, the priority is `dmaLast`, then `dmaSecondLast`, then `dmaActive`/`dmaTrigger`, then `cpuDblFirst`, then `cpuWrite`/`cpuDblSecond`, then read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one edge per CPU cycle |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Sample fetch request, sampled when idle |
| fetchAddr | input | ADDR_W | Sample address, latched on acceptance |
| cpuWrite | input | 1 | Current cycle is a single CPU write |
| cpuDblFirst | input | 1 | Current cycle is the first write of a double write |
| cpuDblSecond | input | 1 | Current cycle is the second write of a double write |
| dmaActive | input | 1 | Sprite DMA transfer in progress |
| dmaTrigger | input | 1 | Current cycle is the write that starts sprite DMA |
| dmaSecondLast | input | 1 | Current cycle is the second-last DMA cycle |
| dmaLast | input | 1 | Current cycle is the last DMA cycle |
| cycleEven | input | 1 | 1 on even bus cycles |
| busRdata | input | DATA_W | Read data returned by memory |
| rdy | output | 1 | Bus ready, low while stalled |
| busAddr | output | ADDR_W | Sample address in the drive cycle, else 0 |
| busDrive | output | 1 | High in the cycle the controller owns the bus |
| fetchDone | output | 1 | One-cycle strobe, fetched byte valid |
| fetchData | output | DATA_W | Fetched sample byte |

## Verification
A corrupt stall counter would appear at once as a low period of the wrong length on `rdy`. It would also shift `busDrive` and `fetchDone`, and a single fetch shows both errors. An address register overwritten by a late request would put the wrong value on `busAddr` in the drive cycle of that fetch. A capture taken in the wrong cycle would return 0 instead of the memory byte in the next `fetchDone` cycle. Random fetches cover mixed flag sets, parity and addresses. Directed fetches cover each case, the priority clashes and requests that arrive while a stall is in progress.

// File: rtl/fsc_pkg.sv
`timescale 1ns/1ps
package fsc_pkg;
  // stall lengths per bus situation (cycles of low ready, even alignment)
  localparam int unsigned READ_STALL      = 4;
  localparam int unsigned WRITE_STALL     = 3;
  localparam int unsigned DBL_FIRST_STALL = 4;
  localparam int unsigned DMA_STALL       = 2;
  localparam int unsigned DMA_PENULT_STALL = 1;
  localparam int unsigned DMA_FINAL_STALL = 3;
  localparam int unsigned MAX_STALL       = 5;
  localparam int unsigned CNT_W           = $clog2(MAX_STALL + 1);

  typedef struct packed {
    logic loadAddr;
    logic capture;
  } dpStrobe_t;
endpackage

// File: rtl/fsc_ctrl.sv
`timescale 1ns/1ps
module fsc_ctrl
  import fsc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      fetchReq,
  input  logic      cpuWrite,
  input  logic      cpuDblFirst,
  input  logic      cpuDblSecond,
  input  logic      dmaActive,
  input  logic      dmaTrigger,
  input  logic      dmaSecondLast,
  input  logic      dmaLast,
  input  logic      cycleEven,
  output logic      rdy,
  output logic      busDrive,
  output logic      fetchDone,
  output dpStrobe_t strobe
);
  logic [CNT_W-1:0] stallCnt;
  logic [CNT_W-1:0] baseLen;
  logic [CNT_W-1:0] totalLen;
  logic             accept;

  // case selection, highest priority first
  always_comb begin
    if (dmaLast)                       baseLen = CNT_W'(DMA_FINAL_STALL);
    else if (dmaSecondLast)            baseLen = CNT_W'(DMA_PENULT_STALL);
    else if (dmaActive || dmaTrigger)  baseLen = CNT_W'(DMA_STALL);
    else if (cpuDblFirst)              baseLen = CNT_W'(DBL_FIRST_STALL);
    else if (cpuWrite || cpuDblSecond) baseLen = CNT_W'(WRITE_STALL);
    else                               baseLen = CNT_W'(READ_STALL);
    totalLen = baseLen + (cycleEven ? CNT_W'(0) : CNT_W'(1));
  end

  assign accept          = fetchReq && (stallCnt == '0);
  assign rdy             = (stallCnt == '0);
  assign busDrive        = (stallCnt == CNT_W'(1));
  assign strobe.loadAddr = accept;
  assign strobe.capture  = busDrive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt  <= '0;
      fetchDone <= 1'b0;
    end else begin
      fetchDone <= busDrive;
      if (accept)              stallCnt <= totalLen;
      else if (stallCnt != '0) stallCnt <= stallCnt - CNT_W'(1);
    end
  end

  // R10: done is a single-cycle strobe
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    fetchDone |=> !fetchDone);
  // R9: bus is only driven while the CPU is held
  p_drive_in_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> !rdy);
  // R9/R10: drive cycle is the last stalled one, followed by done with ready high
  p_drive_then_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |=> (fetchDone && rdy));
  // R11: a running stall only counts down, requests do not reload it
  p_stall_countdown_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stallCnt != '0) |=> (stallCnt == $past(stallCnt) - CNT_W'(1)));
  // R6: second-last DMA cycle on even parity drives the bus in the next cycle
  p_penult_one_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accept && dmaSecondLast && !dmaLast && cycleEven) |=> busDrive);
endmodule

// File: rtl/fsc_dpath.sv
`timescale 1ns/1ps
module fsc_dpath
  import fsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] fetchData
);
  logic [ADDR_W-1:0] addrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      fetchData <= '0;
    end else begin
      if (strobe.loadAddr) addrReg   <= fetchAddr;
      if (strobe.capture)  fetchData <= busRdata;
    end
  end

  assign busAddr = strobe.capture ? addrReg : '0;

  // R11: the latched address survives until the next accepted request
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadAddr && $past(rstN)) |=> $stable(addrReg));
  // R10: the captured byte is what memory returned in the drive cycle
  p_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (fetchData == $past(busRdata)));
endmodule

// File: rtl/fetch_stall_ctrl.sv
`timescale 1ns/1ps
module fetch_stall_ctrl
  import fsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              cpuWrite,
  input  logic              cpuDblFirst,
  input  logic              cpuDblSecond,
  input  logic              dmaActive,
  input  logic              dmaTrigger,
  input  logic              dmaSecondLast,
  input  logic              dmaLast,
  input  logic              cycleEven,
  input  logic [DATA_W-1:0] busRdata,
  output logic              rdy,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busDrive,
  output logic              fetchDone,
  output logic [DATA_W-1:0] fetchData
);
  dpStrobe_t strobe;

  fsc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq),
    .cpuWrite(cpuWrite), .cpuDblFirst(cpuDblFirst), .cpuDblSecond(cpuDblSecond),
    .dmaActive(dmaActive), .dmaTrigger(dmaTrigger),
    .dmaSecondLast(dmaSecondLast), .dmaLast(dmaLast), .cycleEven(cycleEven),
    .rdy(rdy), .busDrive(busDrive), .fetchDone(fetchDone), .strobe(strobe)
  );

  fsc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchAddr(fetchAddr),
    .busRdata(busRdata), .busAddr(busAddr), .fetchData(fetchData)
  );
endmodule

// File: tb/fetch_stall_ctrl_tb_top.sv
`timescale 1ns/1ps
module fetch_stall_ctrl_tb_top;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchReq = 1'b0;
  logic [AW-1:0] fetchAddr = '0;
  logic cpuWrite = 0, cpuDblFirst = 0, cpuDblSecond = 0;
  logic dmaActive = 0, dmaTrigger = 0, dmaSecondLast = 0, dmaLast = 0;
  logic cycleEven = 1'b1;
  logic [DW-1:0] busRdata;
  logic rdy, busDrive, fetchDone;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] fetchData;

  int checkCnt = 0;
  int failCnt = 0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] memByte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign busRdata = busDrive ? memByte(busAddr) : '0;

  fetch_stall_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .cpuWrite(cpuWrite), .cpuDblFirst(cpuDblFirst), .cpuDblSecond(cpuDblSecond),
    .dmaActive(dmaActive), .dmaTrigger(dmaTrigger),
    .dmaSecondLast(dmaSecondLast), .dmaLast(dmaLast), .cycleEven(cycleEven),
    .busRdata(busRdata), .rdy(rdy), .busAddr(busAddr), .busDrive(busDrive),
    .fetchDone(fetchDone), .fetchData(fetchData)
  );

  // flag vector: {dmaLast, dmaSecondLast, dmaTrigger, dmaActive, cpuDblFirst, cpuDblSecond, cpuWrite}
  function automatic int expLen(input logic [6:0] f, input logic even);
    int base;
    if (f[6])                base = 3;  // R7
    else if (f[5])           base = 1;  // R6
    else if (f[4] || f[3])   base = 2;  // R5
    else if (f[2])           base = 4;  // R4
    else if (f[1] || f[0])   base = 3;  // R3
    else                     base = 4;  // R2
    return base + (even ? 0 : 1);       // R8
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setFlags(input logic [6:0] f);
    {dmaLast, dmaSecondLast, dmaTrigger, dmaActive, cpuDblFirst, cpuDblSecond, cpuWrite} = f;
  endtask

  task automatic runFetch(input string req, input logic [6:0] f, input logic even,
                          input logic [AW-1:0] addr, input bit inject);
    int lowCnt = 0;
    int drives = 0;
    int badAddr = 0;
    bit doneSeen = 0;
    logic [DW-1:0] gotData = '0;
    logic rdyAtDone = 1'b0;
    int exp = expLen(f, even);
    @(negedge clk);
    setFlags(f);
    cycleEven = even;
    fetchAddr = addr;
    fetchReq  = 1'b1;
    for (int i = 0; i < 12 && !doneSeen; i++) begin
      @(negedge clk);
      if (!rdy) lowCnt++;
      if (busDrive) begin
        drives++;
        if (busAddr !== addr) badAddr++;
      end else if (busAddr !== '0) badAddr++;
      if (fetchDone) begin
        doneSeen = 1;
        gotData = fetchData;
        rdyAtDone = rdy;
      end
      // R12: flags change after acceptance; R11: late request with another address
      setFlags(7'h7F ^ f);
      cycleEven = ~even;
      if (i == 0 && inject) begin
        fetchReq  = 1'b1;
        fetchAddr = ~addr;
      end else begin
        fetchReq = 1'b0;
      end
    end
    check({req, " stall length"}, lowCnt == exp, lowCnt, exp);
    check("R9 single drive cycle", drives == 1, drives, 1);
    check("R9 bus address", badAddr == 0, badAddr, 0);
    check("R10 done seen", doneSeen, int'(doneSeen), 1);
    check("R10 rdy high at done", rdyAtDone === 1'b1, int'(rdyAtDone), 1);
    check("R10 fetched byte", gotData === memByte(addr), int'(gotData), int'(memByte(addr)));
    setFlags('0);
    cycleEven = 1'b1;
    @(negedge clk);
    check("R10 done width", fetchDone === 1'b0, int'(fetchDone), 0);
    check("R11 no extra stall", rdy === 1'b1, int'(rdy), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdy", rdy === 1'b1, int'(rdy), 1);
    check("R1 busDrive", busDrive === 1'b0, int'(busDrive), 0);
    check("R1 fetchDone", fetchDone === 1'b0, int'(fetchDone), 0);
    check("R1 busAddr", busAddr === '0, int'(busAddr), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", rdy === 1'b1 && fetchDone === 1'b0, int'(rdy), 1);

    runFetch("R2 read",           7'b000_0000, 1'b1, 16'hC000, 0);
    runFetch("R3 single write",   7'b000_0001, 1'b1, 16'hC040, 0);
    runFetch("R3 second write",   7'b000_0010, 1'b1, 16'hC123, 0);
    runFetch("R4 first write",    7'b000_0100, 1'b1, 16'hD000, 0);
    runFetch("R5 dma active",     7'b000_1000, 1'b1, 16'hE001, 0);
    runFetch("R5 dma trigger",    7'b001_0000, 1'b1, 16'hE0F0, 0);
    runFetch("R6 dma second-last",7'b010_1000, 1'b1, 16'hFFFF, 0);
    runFetch("R7 dma last",       7'b100_1000, 1'b1, 16'h8000, 0);
    runFetch("R8 odd read",       7'b000_0000, 1'b0, 16'h8001, 0);
    runFetch("R8 odd second-last",7'b010_0000, 1'b0, 16'h0000, 0);
    runFetch("R12 all flags",     7'b111_1111, 1'b1, 16'hA55A, 0);
    runFetch("R12 dma over write",7'b000_1101, 1'b1, 16'h1234, 0);
    runFetch("R12 first over second", 7'b000_0110, 1'b1, 16'h4321, 0);
    runFetch("R11 late request",  7'b000_0000, 1'b1, 16'hBEEF, 1);
    runFetch("R11 late request short", 7'b010_0000, 1'b1, 16'h0F0F, 1);

    for (int n = 0; n < 60; n++) begin
      logic [6:0] f;
      for (int b = 0; b < 7; b++) f[b] = ($urandom % 4) == 0;
      runFetch("R12 random", f, 1'($urandom), 16'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule